// File: doc/BRIEF.md
# Time-Sliced Ten-Context Processor Core

This block runs ten small independent processors on one shared adder and one shared decoder. Each processor is a context. Its working state is 52 bits: a 12-bit program counter, an 18-bit accumulator, a latched instruction word, a step phase and a latched opcode. All ten states move around a ring of registers. On every clock (a minor cycle) the context at the head of the ring passes through the execution slot. It advances by exactly one instruction step and goes back in at the tail of the ring. A full trip around the ring takes ten clocks. Each context gets one step in every ten clocks, whatever the other contexts are doing.

Each context has a private local memory. That memory holds both its program and its data. It is read combinationally during the context's slot, so every access finishes well within one trip around the ring. Some instructions need a second step: those that read a memory operand, and those that carry a second 12-bit word. Such an instruction stores its decoded opcode in the context state and finishes on the context's next visit.

The step phase is a small state machine kept inside each context. FETCH reads the word at the program counter. It either completes a one-step instruction and stays in FETCH, moves to OPERAND for a two-step instruction, or moves to HALTED on the halt opcode. OPERAND completes the latched instruction and returns to FETCH. HALTED has no exit except reset.

The program is loaded through a write port while reset is held. The ring head is visible at the outputs, so the state of context n appears on clocks congruent to n modulo ten.

Top module: `pp_barrel`

## Requirements
- R1: While reset is asserted, and on the ten clocks after it is released, the head of the ring shows a program counter of 0, an accumulator of 0 and no halt. After release, the context index starts at 0.
- R2: `slot_idx` counts 0,1,...,9,0,... and advances by one on every clock after reset. Context n is at the head, and is stepped, only on clocks with index n.
- R3: A context's state changes only during its own slot. On visit k (k = 0,1,...) the outputs show that context's state after exactly k steps.
- R4: Instruction words hold the opcode in bits [11:6] and a 6-bit operand d in bits [5:0]. The one-step immediate opcodes are 1 (load d), 2 (add d) and 3 (subtract d). The value d is zero-extended, the arithmetic wraps modulo 2^18, and the program counter advances by 1.
- R5: The memory opcodes are 4 (load), 5 (add) and 6 (subtract). They use the zero-extended word at local address d and take two steps. After the first step the program counter has advanced by 1 and the accumulator is unchanged. The result appears after the second step.
- R6: Opcode 7 ANDs the accumulator with the zero-extended word at local address d. It takes two steps.
- R7: Opcode 8 is a two-word conditional jump that takes two steps. If the accumulator is zero, the program counter becomes the second word. Otherwise it skips past the second word (opcode address + 2).
- R8: Opcode 9 is a two-word constant load that takes two steps. The accumulator becomes {d, second word} and the program counter ends at opcode address + 2.
- R9: Opcode 0 halts the context. The program counter stays at the halt address, `slot_halt` is set, and the context's state never changes again. Its slot still comes round every ten clocks.
- R10: Each context runs its own program against its own memory. Its results do not depend on what the other nine contexts execute.
- R11: Any opcode above 9 is a one-step no-operation that only advances the program counter by 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Minor-cycle clock |
| rst_n | input | 1 | Active-low synchronous reset of the ring and the index counter |
| load_en | input | 1 | Writes `load_data` into a local memory on this clock |
| load_ctx | input | IDX_W (4) | Context whose memory is written |
| load_addr | input | MEM_AW (8) | Word address within that memory |
| load_data | input | 12 | Word to write |
| slot_idx | output | IDX_W (4) | Index of the context now in the slot |
| slot_pc | output | 12 | Program counter of the context in the slot |
| slot_acc | output | 18 | Accumulator of the context in the slot |
| slot_halt | output | 1 | The context in the slot is halted |

## Verification
Each of the ten contexts runs a different program, so a single run exercises every opcode class side by side. Immediate arithmetic, including a subtract that wraps below zero, separates one-step from two-step sequencing. The memory-operand chain of load, add and AND is sampled both in the middle of an instruction and after it, which shows whether an instruction completes too early. The conditional jump is tried once with a zero accumulator and once with a non-zero one. Three long straight-line programs keep running after the short programs have halted, which shows that a halted context neither freezes the rotation nor disturbs its neighbours. A sweep of the index on every clock confirms the fixed slot pattern.

// File: rtl/pp_pkg.sv
`timescale 1ns/1ps
package pp_pkg;
    localparam int PC_W   = 12;
    localparam int ACC_W  = 18;
    localparam int WORD_W = 12;
    localparam int OP_W   = 6;

    typedef enum logic [3:0] {
        PH_FETCH = 4'd0,
        PH_OPER  = 4'd1,
        PH_HALT  = 4'd15
    } phase_e;

    // 52-bit context record carried around the ring
    typedef struct packed {
        logic [PC_W-1:0]   pc;
        logic [ACC_W-1:0]  acc;
        logic [WORD_W-1:0] iw;
        phase_e            step;
        logic [OP_W-1:0]   op;
    } ctx_t;

    localparam logic [OP_W-1:0] OP_HALT = 6'd0;
    localparam logic [OP_W-1:0] OP_LDN  = 6'd1;
    localparam logic [OP_W-1:0] OP_ADN  = 6'd2;
    localparam logic [OP_W-1:0] OP_SBN  = 6'd3;
    localparam logic [OP_W-1:0] OP_LDM  = 6'd4;
    localparam logic [OP_W-1:0] OP_ADM  = 6'd5;
    localparam logic [OP_W-1:0] OP_SBM  = 6'd6;
    localparam logic [OP_W-1:0] OP_ANM  = 6'd7;
    localparam logic [OP_W-1:0] OP_ZJP  = 6'd8;
    localparam logic [OP_W-1:0] OP_LDK  = 6'd9;
endpackage

// File: rtl/pp_mem.sv
`timescale 1ns/1ps
module pp_mem #(
    parameter int NCTX   = 10,
    parameter int MEM_AW = 8,
    localparam int IDX_W = $clog2(NCTX),
    localparam int DEPTH = 1 << MEM_AW
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_ctx,
    input  logic [MEM_AW-1:0] wr_addr,
    input  logic [11:0]       wr_data,
    input  logic [IDX_W-1:0]  rd_ctx,
    input  logic [MEM_AW-1:0] rd_addr,
    output logic [11:0]       rd_data
);
    logic [11:0] bank_rd [NCTX];

    // one private bank per context
    for (genvar c = 0; c < NCTX; c++) begin : g_bank
        logic [11:0] words [DEPTH];
        always_ff @(posedge clk) begin
            if (wr_en && wr_ctx == IDX_W'(c))
                words[wr_addr] <= wr_data;
        end
        assign bank_rd[c] = words[rd_addr];
    end

    assign rd_data = bank_rd[rd_ctx];
endmodule

// File: rtl/pp_slot.sv
`timescale 1ns/1ps
module pp_slot
    import pp_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  ctx_t              cur,
    output logic [MEM_AW-1:0] rd_addr,
    input  logic [11:0]       rd_data,
    output ctx_t              nxt
);
    logic [OP_W-1:0]  fop;
    logic [ACC_W-1:0] imm;
    logic [ACC_W-1:0] opnd;

    assign fop  = rd_data[11:6];
    assign imm  = ACC_W'(rd_data[5:0]);
    assign opnd = ACC_W'(rd_data);

    // address selection: operand fetch for memory ops, else program counter
    always_comb begin
        rd_addr = cur.pc[MEM_AW-1:0];
        if (cur.step == PH_OPER && cur.op >= OP_LDM && cur.op <= OP_ANM)
            rd_addr = MEM_AW'(cur.iw[5:0]);
    end

    // step phase transitions and data updates
    always_comb begin
        nxt = cur;
        unique case (cur.step)
            PH_FETCH: begin
                nxt.pc = cur.pc + 1'b1;
                case (fop)
                    OP_HALT: begin
                        nxt.pc   = cur.pc;
                        nxt.step = PH_HALT;
                    end
                    OP_LDN: nxt.acc = imm;
                    OP_ADN: nxt.acc = cur.acc + imm;
                    OP_SBN: nxt.acc = cur.acc - imm;
                    OP_LDM, OP_ADM, OP_SBM, OP_ANM, OP_ZJP, OP_LDK: begin
                        nxt.iw   = rd_data;
                        nxt.op   = fop;
                        nxt.step = PH_OPER;
                    end
                    default: ;
                endcase
            end
            PH_OPER: begin
                nxt.step = PH_FETCH;
                case (cur.op)
                    OP_LDM: nxt.acc = opnd;
                    OP_ADM: nxt.acc = cur.acc + opnd;
                    OP_SBM: nxt.acc = cur.acc - opnd;
                    OP_ANM: nxt.acc = cur.acc & opnd;
                    OP_ZJP: nxt.pc  = (cur.acc == '0) ? rd_data : cur.pc + 1'b1;
                    OP_LDK: begin
                        nxt.acc = {cur.iw[5:0], rd_data};
                        nxt.pc  = cur.pc + 1'b1;
                    end
                    default: ;
                endcase
            end
            PH_HALT: ;
            default: nxt.step = PH_HALT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst_n) begin
            if (cur.step == PH_HALT)
                p_halt_frozen_r9: assert (nxt == cur)
                    else $error("halted context changed");
            if (cur.step == PH_FETCH && fop >= OP_LDM && fop <= OP_LDK)
                p_first_step_r5: assert (nxt.step == PH_OPER && nxt.acc == cur.acc
                                         && nxt.pc == cur.pc + 1'b1)
                    else $error("two-step op finished early");
            if (cur.step == PH_OPER)
                p_second_step_r5: assert (nxt.step == PH_FETCH)
                    else $error("operand step did not return to fetch");
            if (cur.step == PH_FETCH && fop > OP_LDK)
                p_unknown_nop_r11: assert (nxt.acc == cur.acc && nxt.step == PH_FETCH)
                    else $error("unknown opcode changed state");
        end
    end
endmodule

// File: rtl/pp_ring.sv
`timescale 1ns/1ps
module pp_ring
    import pp_pkg::*;
#(
    parameter int NCTX = 10,
    localparam int IDX_W = $clog2(NCTX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  ctx_t             nxt,
    output ctx_t             head,
    output logic [IDX_W-1:0] slot_idx
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NCTX - 1);
    localparam ctx_t CTX_RST = '{pc: '0, acc: '0, iw: '0, step: PH_FETCH, op: '0};

    ctx_t ring_q [NCTX];

    // ring shift: head leaves through the slot, returns at the tail
    for (genvar i = 0; i < NCTX; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n)
                ring_q[i] <= CTX_RST;
            else if (i == NCTX - 1)
                ring_q[i] <= nxt;
            else
                ring_q[i] <= ring_q[(i + 1) % NCTX];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            slot_idx <= '0;
        else if (slot_idx == LAST)
            slot_idx <= '0;
        else
            slot_idx <= slot_idx + 1'b1;
    end

    assign head = ring_q[0];

    p_reset_home_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (slot_idx == '0 && head.pc == '0 && head.acc == '0))
        else $error("ring not at home state after reset");
    p_idx_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx == LAST) |=> (slot_idx == '0))
        else $error("slot index failed to wrap");
    p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_idx != LAST) |=> (slot_idx == $past(slot_idx) + 1'b1))
        else $error("slot index skipped");
    p_idx_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        slot_idx <= LAST)
        else $error("slot index out of range");
endmodule

// File: rtl/pp_barrel.sv
`timescale 1ns/1ps
module pp_barrel
    import pp_pkg::*;
#(
    parameter int NCTX   = 10,
    parameter int MEM_AW = 8,
    localparam int IDX_W = $clog2(NCTX)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_en,
    input  logic [IDX_W-1:0]  load_ctx,
    input  logic [MEM_AW-1:0] load_addr,
    input  logic [11:0]       load_data,
    output logic [IDX_W-1:0]  slot_idx,
    output logic [11:0]       slot_pc,
    output logic [17:0]       slot_acc,
    output logic              slot_halt
);
    ctx_t              head;
    ctx_t              nxt;
    logic [MEM_AW-1:0] rd_addr;
    logic [11:0]       rd_data;

    pp_ring #(.NCTX(NCTX)) ring_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .nxt      (nxt),
        .head     (head),
        .slot_idx (slot_idx)
    );

    pp_slot #(.MEM_AW(MEM_AW)) slot_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cur     (head),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .nxt     (nxt)
    );

    pp_mem #(.NCTX(NCTX), .MEM_AW(MEM_AW)) mem_i (
        .clk     (clk),
        .wr_en   (load_en),
        .wr_ctx  (load_ctx),
        .wr_addr (load_addr),
        .wr_data (load_data),
        .rd_ctx  (slot_idx),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );

    always_comb begin
        slot_pc   = head.pc;
        slot_acc  = head.acc;
        slot_halt = (head.step == PH_HALT);
    end
endmodule

// File: tb/pp_barrel_tb_top.sv
`timescale 1ns/1ps
module pp_barrel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_en = 1'b0;
    logic [3:0]  load_ctx = '0;
    logic [7:0]  load_addr = '0;
    logic [11:0] load_data = '0;
    logic [3:0]  slot_idx;
    logic [11:0] slot_pc;
    logic [17:0] slot_acc;
    logic        slot_halt;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    pp_barrel dut_i (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_ctx(load_ctx),
        .load_addr(load_addr), .load_data(load_data), .slot_idx(slot_idx),
        .slot_pc(slot_pc), .slot_acc(slot_acc), .slot_halt(slot_halt)
    );

    always @(posedge clk) if (rst_n) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // R2: index sweep on every clock after reset
    always @(negedge clk) begin
        if (rst_n && !done)
            chk(slot_idx == 4'(cyc % 10), "R2", "slot_idx", slot_idx, cyc % 10);
    end

    function automatic logic [11:0] ins(input int op, input int d);
        return {op[5:0], d[5:0]};
    endfunction

    task automatic wr(input int c, input int a, input int w);
        @(negedge clk);
        load_en = 1'b1; load_ctx = 4'(c); load_addr = 8'(a); load_data = 12'(w);
    endtask

    task automatic visit(input int c, input int k, input int pc, input int acc,
                         input bit h, input string req);
        while (cyc < c + 10 * k) @(negedge clk);
        chk(slot_idx == 4'(c), req, "index at visit", slot_idx, c);
        chk(slot_pc == 12'(pc), req, "pc", slot_pc, pc);
        chk(slot_acc == 18'(acc), req, "acc", slot_acc, acc);
        chk(slot_halt == h, req, "halt", slot_halt, h);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        // ctx0: immediates then halt (R4, R9)
        wr(0, 0, ins(1, 5)); wr(0, 1, ins(2, 7)); wr(0, 2, ins(3, 2)); wr(0, 3, ins(0, 0));
        // ctx1: subtract wraps below zero (R4)
        wr(1, 0, ins(3, 1)); wr(1, 1, ins(0, 0));
        // ctx2: memory load, add, AND (R5, R6)
        wr(2, 0, ins(4, 40)); wr(2, 1, ins(5, 41)); wr(2, 2, ins(7, 42)); wr(2, 3, ins(0, 0));
        wr(2, 40, 'hABC); wr(2, 41, 'h123); wr(2, 42, 'h0F0);
        // ctx3: constant load then memory subtract (R8, R5)
        wr(3, 0, ins(9, 'h15)); wr(3, 1, 'hABC); wr(3, 2, ins(6, 20)); wr(3, 3, ins(0, 0));
        wr(3, 20, 'hABD);
        // ctx4: jump taken on zero (R7)
        wr(4, 0, ins(8, 0)); wr(4, 1, 10); wr(4, 10, ins(1, 9)); wr(4, 11, ins(0, 0));
        // ctx5: jump not taken (R7)
        wr(5, 0, ins(1, 1)); wr(5, 1, ins(8, 0)); wr(5, 2, 20); wr(5, 3, ins(1, 3));
        wr(5, 4, ins(0, 0)); wr(5, 20, ins(1, 63)); wr(5, 21, ins(0, 0));
        // ctx6: unknown opcode is a no-op (R11)
        wr(6, 0, ins(63, 0)); wr(6, 1, ins(1, 4)); wr(6, 2, ins(0, 0));
        // ctx7..9: long add chains keep running (R10)
        for (int c = 7; c < 10; c++) begin
            for (int a = 0; a < 200; a++) wr(c, a, ins(2, (c == 9) ? 63 : c - 6));
            wr(c, 200, ins(0, 0));
        end
        @(negedge clk);
        load_en = 1'b0;
        // R1: reset state at the ring head
        chk(slot_idx == 0, "R1", "idx in reset", slot_idx, 0);
        chk(slot_pc == 0 && slot_acc == 0 && !slot_halt, "R1", "head in reset",
            {slot_pc, slot_acc}, 0);
        rst_n = 1'b1;
        for (int c = 0; c < 10; c++) visit(c, 0, 0, 0, 1'b0, "R1");
        visit(0, 1, 1, 5, 1'b0, "R3");
        visit(2, 1, 1, 0, 1'b0, "R5");
        visit(6, 1, 1, 0, 1'b0, "R11");
        visit(0, 2, 2, 12, 1'b0, "R4");
        visit(2, 2, 1, 'hABC, 1'b0, "R5");
        visit(3, 2, 2, 'h15ABC, 1'b0, "R8");
        visit(4, 2, 10, 0, 1'b0, "R7");
        visit(0, 3, 3, 10, 1'b0, "R4");
        visit(5, 3, 3, 1, 1'b0, "R7");
        visit(0, 4, 3, 10, 1'b1, "R9");
        visit(0, 5, 3, 10, 1'b1, "R9");
        // final states after every program has ended (R10 with per-op tags)
        visit(0, 300, 3, 10, 1'b1, "R9");
        visit(1, 300, 1, 'h3FFFF, 1'b1, "R4");
        visit(2, 300, 3, 'h0D0, 1'b1, "R6");
        visit(3, 300, 3, 'h14FFF, 1'b1, "R5");
        visit(4, 300, 11, 9, 1'b1, "R7");
        visit(5, 300, 4, 3, 1'b1, "R7");
        visit(6, 300, 2, 4, 1'b1, "R11");
        visit(7, 300, 200, 200, 1'b1, "R10");
        visit(8, 300, 200, 400, 1'b1, "R10");
        visit(9, 300, 200, 12600, 1'b1, "R10");
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 3009);
            finish_run();
        end
    end
endmodule